// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Converter

This block turns a 32-bit binary floating-point word into a 32-bit signed two's-complement integer. Each request carries its own 2-bit rounding direction, so back-to-back conversions may use different modes. Every encoding is decoded: normal values, subnormals, signed zeros, infinities and not-a-number patterns.

The converter is a short pipeline. The input word is unpacked into sign, class, effective exponent and 24-bit significand. The significand is then shifted to the integer binary point while the first discarded bit and the OR of the remaining discarded bits are kept. The magnitude is rounded, range-checked and given its sign. One register stage holds the result. When no request is presented, the held result and flags keep their last values.

Top module: `f2i_conv`

## Requirements
- R1: The result, `out_vld`, `invalid` and `inexact` are registered. `out_vld` is high exactly one cycle after `in_vld` was high. Synchronous reset clears `out_vld`, `res`, `invalid` and `inexact` to 0.
- R2: The input is decoded as sign bit 31, biased exponent bits 30..23 (bias 127) and fraction bits 22..0. A normal value is (1 + fraction) × 2^(exp-127), negated when the sign is 1. Values that are already integers convert exactly, with no flags.
- R3: Exponent 0 with fraction 0 gives result 0 and no flags, for both sign values. Exponent 0 with a nonzero fraction is a subnormal: it has no hidden 1 and an exponent of -126. It rounds like any other value below one.
- R4: Mode 00 rounds to nearest, and exact halves go to the even integer: 2.5→2, 3.5→4, -2.5→-2, 1.5→2, 0.5→0, 2.6→3.
- R5: Mode 01 rounds toward zero: 1.9→1, -1.9→-1. Any magnitude below one gives 0.
- R6: Mode 10 rounds toward +infinity: 2.1→3, -2.1→-2. A positive subnormal gives 1.
- R7: Mode 11 rounds toward -infinity: 1.9→1, -1.9→-2. A negative subnormal gives -1 (0xFFFFFFFF).
- R8: `inexact` is 1 when a valid conversion discarded a nonzero fraction bit, and 0 otherwise. It is always 0 when `invalid` is 1.
- R9: Exponent 255 raises `invalid`. With fraction 0 (infinity) the result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1. With a nonzero fraction (NaN) the result is 0x80000000 for either sign.
- R10: A rounded value outside [-2^31, 2^31-1] raises `invalid` and saturates to 0x7FFFFFFF when positive and 0x80000000 when negative. Exactly -2^31 (0xCF000000) is valid and gives 0x80000000 with no flags.
- R11: While `in_vld` is low, `res`, `invalid` and `inexact` keep their previous values, whatever is on `fp_in` and `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Conversion request strobe |
| fp_in | input | 32 | Single-precision operand |
| mode | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 up, 11 down |
| out_vld | output | 1 | Result strobe, one cycle after the request |
| res | output | 32 | Signed integer result |
| invalid | output | 1 | NaN, infinity or out-of-range operand |
| inexact | output | 1 | Discarded fraction bits were nonzero |

## Verification
The hardest cases to reach are at the edges of the signed range. Here one bit of the exponent or significand decides between an exact result, a valid -2^31 and saturation. The stimulus uses hand-built encodings that sit just inside and just outside those limits: 0x4EFFFFFF, 0x4F000000, 0xCF000000 and 0xCF000001. Tie cases need a first discarded bit of 1 with all lower bits 0, so exact halves are driven under each mode beside near-halves such as 2.6. Subnormals are driven under the directed modes, because only those modes turn them into a nonzero result.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int INT_W  = 32;
    localparam int MANT_W = FRAC_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP_I = (1 << EXP_W) - 1;
    // biased exponent at which the significand LSB carries weight one
    localparam int UNIT_I = BIAS + FRAC_W;
    // largest biased exponent whose integer still fits a signed INT_W word
    localparam int FIT_I  = BIAS + INT_W - 1;

    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(EXP_TOP_I);
    localparam logic [EXP_W-1:0] UNIT_E  = EXP_W'(UNIT_I);
    localparam logic [EXP_W-1:0] FIT_E   = EXP_W'(FIT_I);
    localparam logic [EXP_W-1:0] RSH_CAP = EXP_W'(MANT_W + 1);

    localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_UP        = 2'b10,
        RM_DOWN      = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        CL_FINITE = 2'd0,
        CL_INF    = 2'd1,
        CL_NAN    = 2'd2
    } fclass_e;

    typedef struct packed {
        logic              sign;
        fclass_e           cls;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
    } unpacked_t;

    typedef struct packed {
        logic             sign;
        logic             special;
        logic             nan;
        logic             too_big;
        logic [INT_W-1:0] whole;
        logic             guard;
        logic             sticky;
    } aligned_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } conv_t;

    function automatic logic bump(rmode_e m, logic sign, logic lsb,
                                  logic guard, logic sticky);
        logic lost;
        lost = guard | sticky;
        case (m)
            RM_NEAR_EVEN: bump = guard & (sticky | lsb);
            RM_TO_ZERO:   bump = 1'b0;
            RM_UP:        bump = ~sign & lost;
            default:      bump = sign & lost;
        endcase
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [INT_W-1:0] word,
    output unpacked_t        u
);
    logic [EXP_W-1:0]  efield;
    logic [FRAC_W-1:0] frac;
    logic              exp_zero;

    assign efield   = word[FRAC_W +: EXP_W];
    assign frac     = word[FRAC_W-1:0];
    assign exp_zero = (efield == '0);

    always_comb begin
        u.sign = word[INT_W-1];
        // subnormals share the exponent of the smallest normal, without hidden 1
        u.exp  = exp_zero ? EXP_W'(1) : efield;
        u.mant = {~exp_zero, frac};
        if (efield == EXP_TOP)
            u.cls = (frac == '0) ? CL_INF : CL_NAN;
        else
            u.cls = CL_FINITE;
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  unpacked_t u,
    output aligned_t  a
);
    logic [EXP_W-1:0]    lsh;
    logic [EXP_W-1:0]    rsh_raw;
    logic [EXP_W-1:0]    rsh;
    logic [2*MANT_W:0]   wide;

    assign lsh     = u.exp - UNIT_E;
    assign rsh_raw = UNIT_E - u.exp;
    assign rsh     = (rsh_raw > RSH_CAP) ? RSH_CAP : rsh_raw;
    assign wide    = {u.mant, {(MANT_W+1){1'b0}}} >> rsh;

    always_comb begin
        a.sign    = u.sign;
        a.special = (u.cls != CL_FINITE);
        a.nan     = (u.cls == CL_NAN);
        a.too_big = 1'b0;
        a.guard   = 1'b0;
        a.sticky  = 1'b0;
        if (u.exp >= UNIT_E) begin
            a.too_big = (u.exp > FIT_E);
            a.whole   = INT_W'(u.mant) << lsh;
        end else begin
            a.whole   = INT_W'(wide[2*MANT_W:MANT_W+1]);
            a.guard   = wide[MANT_W];
            a.sticky  = |wide[MANT_W-1:0];
        end
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  aligned_t a,
    input  rmode_e   rm,
    output conv_t    c
);
    localparam logic [INT_W:0] LIM_POS = {2'b00, {(INT_W-1){1'b1}}};
    localparam logic [INT_W:0] LIM_NEG = {2'b01, {(INT_W-1){1'b0}}};

    logic           inc;
    logic [INT_W:0] mag;
    logic           ovf;

    assign inc = bump(rm, a.sign, a.whole[0], a.guard, a.sticky);
    assign mag = {1'b0, a.whole} + (INT_W+1)'(inc);
    assign ovf = a.sign ? (mag > LIM_NEG) : (mag > LIM_POS);

    always_comb begin
        if (a.special || a.too_big || ovf) begin
            c.invalid = 1'b1;
            c.inexact = 1'b0;
            c.value   = (a.nan || a.sign) ? INT_MIN : INT_MAX;
        end else begin
            c.invalid = 1'b0;
            c.inexact = a.guard | a.sticky;
            c.value   = a.sign ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
        end
    end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [INT_W-1:0] fp_in,
    input  logic [1:0]       mode,
    output logic             out_vld,
    output logic [INT_W-1:0] res,
    output logic             invalid,
    output logic             inexact
);
    unpacked_t u;
    aligned_t  a;
    conv_t     c;
    conv_t     q;
    logic      vld_q;

    f2i_unpack u_unpack (.word(fp_in), .u(u));
    f2i_align  u_align  (.u(u), .a(a));
    f2i_round  u_round  (.a(a), .rm(rmode_e'(mode)), .c(c));

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            q     <= '0;
        end else begin
            vld_q <= in_vld;
            if (in_vld)
                q <= c;
        end
    end

    assign out_vld = vld_q;
    assign res     = q.value;
    assign invalid = q.invalid;
    assign inexact = q.inexact;
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk
    import f2i_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [INT_W-1:0] fp_in,
    input logic [1:0]       mode,
    input logic             out_vld,
    input logic [INT_W-1:0] res,
    input logic             invalid,
    input logic             inexact
);
    logic [EXP_W-1:0] ef;
    logic             fz;
    assign ef = fp_in[FRAC_W +: EXP_W];
    assign fz = (fp_in[FRAC_W-1:0] == '0);

    a_r1_vld_rises: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    a_r1_vld_drops: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(res) && $stable(invalid) && $stable(inexact)));
    a_r3_zero: assert property (@(posedge clk) disable iff (rst)
        (in_vld && fp_in[INT_W-2:0] == '0) |=> (res == '0 && !invalid && !inexact));
    a_r5_below_one: assert property (@(posedge clk) disable iff (rst)
        (in_vld && mode == 2'b01 && ef < EXP_W'(BIAS)) |=> (res == '0));
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (rst)
        invalid |-> !inexact);
    a_r9_nan: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ef == EXP_TOP && !fz) |=> (invalid && res == INT_MIN));
    a_r9_inf: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ef == EXP_TOP && fz) |=>
            (invalid && res == ($past(fp_in[INT_W-1]) ? INT_MIN : INT_MAX)));
    a_r10_sat: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (res == INT_MIN || res == INT_MAX));
endmodule

bind f2i_conv f2i_conv_chk u_chk (.*);

// File: tb/sim_f2i_conv.sv
`timescale 1ns/1ps
module sim_f2i_conv;
    typedef struct {
        logic [31:0] r;
        logic        inv;
        logic        inx;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] fp_in = '0;
    logic [1:0]  mode = 2'b00;
    logic        out_vld;
    logic [31:0] res;
    logic        invalid;
    logic        inexact;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    f2i_conv u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .fp_in(fp_in), .mode(mode),
        .out_vld(out_vld), .res(res), .invalid(invalid), .inexact(inexact)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic send(logic [31:0] f, logic [1:0] m, logic [31:0] r,
                        logic inv, logic inx, string tag);
        exp_t e;
        @(negedge clk);
        in_vld = 1'b1;
        fp_in  = f;
        mode   = m;
        e.r = r; e.inv = inv; e.inx = inx; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare each produced result with the oldest expectation
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (sb.size() == 0) begin
                chk("R1 unexpected out_vld", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " res"}, res, e.r);
                chk({e.tag, " invalid"}, {31'd0, invalid}, {31'd0, e.inv});
                chk({e.tag, " inexact"}, {31'd0, inexact}, {31'd0, e.inx});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset out_vld", {31'd0, out_vld}, 32'd0);
        chk("R1 reset res", res, 32'd0);
        chk("R1 reset flags", {30'd0, invalid, inexact}, 32'd0);

        // R2 exact integers
        send(32'h3F800000, 2'b00, 32'd1,        0, 0, "R2 1.0");
        send(32'h4B800001, 2'b11, 32'd16777218, 0, 0, "R2 16777218");
        send(32'hC2F60000, 2'b10, 32'hFFFFFF85, 0, 0, "R2 -123");
        // R3 zeros and subnormals
        send(32'h00000000, 2'b00, 32'd0,        0, 0, "R3 +0");
        send(32'h80000000, 2'b11, 32'd0,        0, 0, "R3 -0");
        send(32'h00000001, 2'b00, 32'd0,        0, 1, "R3 sub rne");
        send(32'h00000001, 2'b10, 32'd1,        0, 1, "R6 sub up");
        send(32'h80000001, 2'b11, 32'hFFFFFFFF, 0, 1, "R7 sub down");
        send(32'h80000001, 2'b10, 32'd0,        0, 1, "R3 negsub up");
        // R4 nearest-even
        send(32'h40200000, 2'b00, 32'd2,        0, 1, "R4 2.5");
        send(32'h40600000, 2'b00, 32'd4,        0, 1, "R4 3.5");
        send(32'hC0200000, 2'b00, 32'hFFFFFFFE, 0, 1, "R4 -2.5");
        send(32'h3FC00000, 2'b00, 32'd2,        0, 1, "R4 1.5");
        send(32'h3F000000, 2'b00, 32'd0,        0, 1, "R4 0.5");
        send(32'h40266666, 2'b00, 32'd3,        0, 1, "R4 2.6");
        // R5 toward zero
        send(32'h3FF33333, 2'b01, 32'd1,        0, 1, "R5 1.9");
        send(32'hBFF33333, 2'b01, 32'hFFFFFFFF, 0, 1, "R5 -1.9");
        // R6 toward +inf
        send(32'h40066666, 2'b10, 32'd3,        0, 1, "R6 2.1");
        send(32'hC0066666, 2'b10, 32'hFFFFFFFE, 0, 1, "R6 -2.1");
        // R7 toward -inf
        send(32'h3FF33333, 2'b11, 32'd1,        0, 1, "R7 1.9");
        send(32'hBFF33333, 2'b11, 32'hFFFFFFFE, 0, 1, "R7 -1.9");
        // R8 exact value in a directed mode leaves inexact low
        send(32'h40800000, 2'b10, 32'd4,        0, 0, "R8 4.0 up");
        // R9 specials
        send(32'h7F800000, 2'b00, 32'h7FFFFFFF, 1, 0, "R9 +inf");
        send(32'hFF800000, 2'b01, 32'h80000000, 1, 0, "R9 -inf");
        send(32'h7FC00000, 2'b10, 32'h80000000, 1, 0, "R9 nan");
        send(32'hFFC00001, 2'b11, 32'h80000000, 1, 0, "R9 -nan");
        // R10 range edges
        send(32'h4F000000, 2'b00, 32'h7FFFFFFF, 1, 0, "R10 2^31");
        send(32'hCF000000, 2'b00, 32'h80000000, 0, 0, "R10 -2^31");
        send(32'h4EFFFFFF, 2'b01, 32'h7FFFFF80, 0, 0, "R10 max fit");
        send(32'hCF000001, 2'b10, 32'h80000000, 1, 0, "R10 below min");
        send(32'h7F7FFFFF, 2'b11, 32'h7FFFFFFF, 1, 0, "R10 huge");
        send(32'h40200000, 2'b01, 32'd2,        0, 1, "R5 2.5");

        // R11: idle with a NaN on the input; outputs must hold
        @(negedge clk);
        in_vld = 1'b0;
        fp_in  = 32'h7FC00000;
        mode   = 2'b10;
        @(negedge clk);
        @(negedge clk);
        chk("R1 idle out_vld", {31'd0, out_vld}, 32'd0);
        chk("R11 hold res", res, 32'd2);
        chk("R11 hold flags", {30'd0, invalid, inexact}, 32'd1);
        chk("R1 all results seen", sb.size(), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule